// File: doc/BRIEF.md
# Coincidence Trigger Controller with Event Queue

This controller runs the front-end chips of a multi-channel detector and decides when an event is taken. After the system reset is released, it holds the chips in reset for a fixed number of clocks. It then sends a one-clock sync strobe at a fixed interval, so that the time counters in every chip stay aligned. It also produces a clock enable that is active one cycle in every few. This enable serves the slower logic that runs on the same clock.

The scintillator lines are watched for rising edges. If enough lines rise in the same cycle, the event is accepted. The block pulses the accept strobe, which tells the chips to copy the event from their latency memories into their event memories. A transfer window of fixed length follows, and coincidences in it are thrown away. At the end of the window the block asks the readout sequencer to read the event and hands over a 16-bit trigger word. Events that arrive while a readout is running are held in a small first-in first-out queue. Each is handed out when the sequencer reports that the current readout is finished. When the queue is full, further events are dropped and counted.

Top module: `coinc_trig_ctrl`

## Requirements
- R1: `fe_reset_o` is high while `rst_n` is low. It stays high until the RST_LEN-th rising clock edge after release (default 16), where it falls, and it stays low from then on.
- R2: `fe_sync_o` is a one-cycle pulse and is never high while `fe_reset_o` is high. The first pulse follows edge RST_LEN+SYNC_PERIOD after release, and the next ones follow every SYNC_PERIOD edges.
- R3: `clk_en_o` is high in exactly one cycle of every CE_DIV cycles, namely after every edge whose count since release is a multiple of CE_DIV.
- R4: A coincidence is defined as at least MIN_MULT lines (default 2) going from low in the previous cycle to high in the current cycle. Fewer rising lines, or lines that only stay high, give no coincidence.
- R5: In the idle state, a coincidence at edge E raises `l1_accept_o` for the one cycle after E. While `fe_reset_o` is high, coincidences produce nothing.
- R6: The readout request `rd_req_o` is a one-cycle pulse that follows edge E+DEAD_LEN. `rd_pattern_o` changes only together with a request. The trigger word is {rising-edge mask in bits 15:8, line levels in bits 7:0}.
- R7: A coincidence during the transfer window has no effect. It gives no accept pulse, it is not queued, and it does not change the overflow count.
- R8: A coincidence during a readout gives an accept pulse and is queued with its trigger word. When `rd_done_i` is seen and the queue is not empty, a request for the oldest entry follows on the next edge, with no transfer window.
- R9: The queue holds Q_DEPTH entries (default 4). A coincidence that arrives while the queue is full during a readout gets no accept pulse. It is dropped, and `ovf_count_o` goes up by one; the count stops at its maximum value.
- R10: If `rd_done_i` arrives while the queue is empty, the block goes back to idle, and a coincidence in that same cycle is handled as a fresh idle event. If `rd_done_i` arrives while the queue is full, the entry it removes frees room, so a coincidence in that same cycle is queued and is not dropped.
- R11: `rd_done_i` has no effect outside a readout, whether the block is idle or in the transfer window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scint_i | input | N_SCINT | Scintillator discriminator levels |
| rd_done_i | input | 1 | Readout sequencer finished the current event |
| fe_reset_o | output | 1 | Reset to the front-end chips |
| fe_sync_o | output | 1 | Periodic counter-sync strobe |
| clk_en_o | output | 1 | Divided clock enable |
| l1_accept_o | output | 1 | Event accept strobe |
| rd_req_o | output | 1 | Readout request strobe |
| rd_pattern_o | output | 2*N_SCINT | Trigger word of the requested event |
| ovf_count_o | output | OVF_W | Number of events dropped because the queue was full |

## Verification
The hardest collision is when a coincidence and the readout-done signal arrive in the same cycle. What that coincidence becomes depends on how full the queue is at that moment. The bench drives both inputs across the same edge in two cases. In the first the queue is empty, and the coincidence must give an accept in that cycle and a request exactly DEAD_LEN cycles later. In the second the queue is full, and the removal must make room, so the coincidence gets an accept, the overflow count stays the same, and its trigger word comes out last when the queue is drained.

// File: rtl/trig_ctrl_pkg.sv
package trig_ctrl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DEAD = 2'd1,
      ST_READ = 2'd2
   } ctrl_state_t;

endpackage

// File: rtl/trig_init_seq.sv
// Power-on reset pulse, periodic counter-sync strobe and divided clock enable.
module trig_init_seq #(
   parameter int RST_LEN     = 16,
   parameter int SYNC_PERIOD = 4096,
   parameter int CE_DIV      = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic fe_reset_o,
   output logic fe_sync_o,
   output logic clk_en_o
);

   localparam int RW = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
   localparam int SW = $clog2(SYNC_PERIOD);
   localparam int CW = (CE_DIV > 1) ? $clog2(CE_DIV) : 1;

   if (RST_LEN < 1) begin : g_bad_rst
      $error("trig_init_seq: RST_LEN must be at least 1");
   end
   if (SYNC_PERIOD < 2) begin : g_bad_sync
      $error("trig_init_seq: SYNC_PERIOD must be at least 2");
   end
   if (CE_DIV < 1) begin : g_bad_ce
      $error("trig_init_seq: CE_DIV must be at least 1");
   end

   logic [RW-1:0] rst_cnt_q;
   logic [SW-1:0] sync_cnt_q;

   // front-end reset: held from system reset for RST_LEN edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_cnt_q  <= '0;
         fe_reset_o <= 1'b1;
      end else if (fe_reset_o) begin
         if (rst_cnt_q == RW'(RST_LEN - 1)) begin
            fe_reset_o <= 1'b0;
         end else begin
            rst_cnt_q <= rst_cnt_q + 1'b1;
         end
      end
   end

   // sync timer runs only once the front-end is out of reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_cnt_q <= '0;
         fe_sync_o  <= 1'b0;
      end else if (!fe_reset_o) begin
         if (sync_cnt_q == SW'(SYNC_PERIOD - 1)) begin
            sync_cnt_q <= '0;
            fe_sync_o  <= 1'b1;
         end else begin
            sync_cnt_q <= sync_cnt_q + 1'b1;
            fe_sync_o  <= 1'b0;
         end
      end
   end

   // divided enable, free running from system reset
   if (CE_DIV == 1) begin : g_ce_full
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) clk_en_o <= 1'b0;
         else        clk_en_o <= 1'b1;
      end
   end else begin : g_ce_div
      logic [CW-1:0] ce_cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ce_cnt_q <= '0;
            clk_en_o <= 1'b0;
         end else begin
            clk_en_o <= (ce_cnt_q == CW'(CE_DIV - 1));
            if (ce_cnt_q == CW'(CE_DIV - 1)) ce_cnt_q <= '0;
            else                             ce_cnt_q <= ce_cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/trig_coinc_det.sv
// Rising-edge multiplicity check across the scintillator lines.
module trig_coinc_det #(
   parameter int N_SCINT  = 8,
   parameter int MIN_MULT = 2,
   localparam int PAT_W   = 2 * N_SCINT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_SCINT-1:0] scint_i,
   output logic               coin_o,
   output logic [PAT_W-1:0]   pattern_o
);

   localparam int CNT_W = $clog2(N_SCINT + 1);

   if (MIN_MULT < 1 || MIN_MULT > N_SCINT) begin : g_bad_mult
      $error("trig_coinc_det: MIN_MULT must lie in 1..N_SCINT");
   end

   logic [N_SCINT-1:0] prev_q;
   logic [N_SCINT-1:0] rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= scint_i;
   end

   assign rise      = scint_i & ~prev_q;
   assign pattern_o = {rise, scint_i};

   if (MIN_MULT == 1) begin : g_any
      assign coin_o = |rise;
   end else begin : g_count
      logic [CNT_W-1:0] n_rise;
      always_comb begin
         n_rise = '0;
         for (int i = 0; i < N_SCINT; i++) begin
            n_rise = n_rise + CNT_W'(rise[i]);
         end
      end
      assign coin_o = (n_rise >= CNT_W'(MIN_MULT));
   end

endmodule

// File: rtl/trig_evt_queue.sv
// Small FIFO of pending trigger words with a saturating drop counter.
module trig_evt_queue #(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 16,
   parameter int OVF_W  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic              push_acc_o,
   output logic [DATA_W-1:0] head_o,
   output logic              empty_o,
   output logic [CNT_W-1:0]  count_o,
   output logic [OVF_W-1:0]  ovf_cnt_o
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 1) begin : g_bad_depth
      $error("trig_evt_queue: DEPTH must be at least 1");
   end
   if (OVF_W < 1) begin : g_bad_ovf
      $error("trig_evt_queue: OVF_W must be at least 1");
   end

   logic [DATA_W-1:0] slot_q [DEPTH];
   logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              do_pop;

   assign empty_o    = (cnt_q == '0);
   assign do_pop     = pop_i && !empty_o;
   // a pop in the same cycle frees the slot the push needs
   assign push_acc_o = push_req_i && ((cnt_q < CNT_W'(DEPTH)) || do_pop);
   assign head_o     = slot_q[rd_ptr_q];
   assign count_o    = cnt_q;

   always_ff @(posedge clk) begin
      if (push_acc_o) slot_q[wr_ptr_q] <= push_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q  <= '0;
         rd_ptr_q  <= '0;
         cnt_q     <= '0;
         ovf_cnt_o <= '0;
      end else begin
         if (push_acc_o) begin
            wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
         end
         if (do_pop) begin
            rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
         end
         case ({push_acc_o, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (push_req_i && !push_acc_o && (ovf_cnt_o != '1)) begin
            ovf_cnt_o <= ovf_cnt_o + 1'b1;
         end
      end
   end

endmodule

// File: rtl/coinc_trig_ctrl.sv
// Trigger acceptance sequencer: accept, transfer window, readout, queue.
module coinc_trig_ctrl import trig_ctrl_pkg::*; #(
   parameter int N_SCINT     = 8,
   parameter int MIN_MULT    = 2,
   parameter int RST_LEN     = 16,
   parameter int SYNC_PERIOD = 4096,
   parameter int DEAD_LEN    = 64,
   parameter int Q_DEPTH     = 4,
   parameter int CE_DIV      = 4,
   parameter int OVF_W       = 8,
   localparam int PAT_W      = 2 * N_SCINT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_SCINT-1:0] scint_i,
   input  logic               rd_done_i,
   output logic               fe_reset_o,
   output logic               fe_sync_o,
   output logic               clk_en_o,
   output logic               l1_accept_o,
   output logic               rd_req_o,
   output logic [PAT_W-1:0]   rd_pattern_o,
   output logic [OVF_W-1:0]   ovf_count_o
);

   localparam int DW    = (DEAD_LEN > 1) ? $clog2(DEAD_LEN) : 1;
   localparam int QCW   = $clog2(Q_DEPTH + 1);

   if (DEAD_LEN < 1) begin : g_bad_dead
      $error("coinc_trig_ctrl: DEAD_LEN must be at least 1");
   end

   ctrl_state_t      st_q;
   logic [DW-1:0]    dead_cnt_q;
   logic [PAT_W-1:0] cur_pat_q;

   logic             coin, coin_live;
   logic [PAT_W-1:0] pattern;
   logic             q_push, q_pop, q_acc, q_empty;
   logic [PAT_W-1:0] q_head;
   logic [QCW-1:0]   q_count;
   logic             dead_phase;

   trig_init_seq #(
      .RST_LEN     (RST_LEN),
      .SYNC_PERIOD (SYNC_PERIOD),
      .CE_DIV      (CE_DIV)
   ) u_init (
      .clk        (clk),
      .rst_n      (rst_n),
      .fe_reset_o (fe_reset_o),
      .fe_sync_o  (fe_sync_o),
      .clk_en_o   (clk_en_o)
   );

   trig_coinc_det #(
      .N_SCINT  (N_SCINT),
      .MIN_MULT (MIN_MULT)
   ) u_coin (
      .clk       (clk),
      .rst_n     (rst_n),
      .scint_i   (scint_i),
      .coin_o    (coin),
      .pattern_o (pattern)
   );

   assign coin_live = coin && !fe_reset_o;

   // a done with nothing pending hands the coincidence to the idle path
   assign q_pop  = (st_q == ST_READ) && rd_done_i && !q_empty;
   assign q_push = (st_q == ST_READ) && coin_live && !(rd_done_i && q_empty);

   trig_evt_queue #(
      .DEPTH  (Q_DEPTH),
      .DATA_W (PAT_W),
      .OVF_W  (OVF_W)
   ) u_queue (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_req_i  (q_push),
      .push_data_i (pattern),
      .pop_i       (q_pop),
      .push_acc_o  (q_acc),
      .head_o      (q_head),
      .empty_o     (q_empty),
      .count_o     (q_count),
      .ovf_cnt_o   (ovf_count_o)
   );

   assign dead_phase = (st_q == ST_DEAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         dead_cnt_q   <= '0;
         cur_pat_q    <= '0;
         l1_accept_o  <= 1'b0;
         rd_req_o     <= 1'b0;
         rd_pattern_o <= '0;
      end else begin
         l1_accept_o <= 1'b0;
         rd_req_o    <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (coin_live) begin
                  l1_accept_o <= 1'b1;
                  cur_pat_q   <= pattern;
                  dead_cnt_q  <= '0;
                  st_q        <= ST_DEAD;
               end
            end
            ST_DEAD: begin
               if (dead_cnt_q == DW'(DEAD_LEN - 1)) begin
                  rd_req_o     <= 1'b1;
                  rd_pattern_o <= cur_pat_q;
                  st_q         <= ST_READ;
               end else begin
                  dead_cnt_q <= dead_cnt_q + 1'b1;
               end
            end
            ST_READ: begin
               if (q_acc) l1_accept_o <= 1'b1;
               if (rd_done_i) begin
                  if (!q_empty) begin
                     rd_req_o     <= 1'b1;
                     rd_pattern_o <= q_head;
                  end else if (coin_live) begin
                     l1_accept_o <= 1'b1;
                     cur_pat_q   <= pattern;
                     dead_cnt_q  <= '0;
                     st_q        <= ST_DEAD;
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/coinc_trig_ctrl_chk.sv
// Temporal checks for coinc_trig_ctrl, attached by bind.
module coinc_trig_ctrl_chk #(
   parameter int PAT_W   = 16,
   parameter int OVF_W   = 8,
   parameter int Q_DEPTH = 4,
   parameter int CE_DIV  = 4,
   parameter int QCW     = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fe_reset,
   input logic             sync,
   input logic             ce,
   input logic             l1,
   input logic             rd_req,
   input logic [PAT_W-1:0] rd_pattern,
   input logic [OVF_W-1:0] ovf,
   input logic [QCW-1:0]   q_count,
   input logic             in_dead
);

   assert_reset_stays_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !fe_reset |=> !fe_reset);

   assert_no_sync_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fe_reset |-> !sync);

   assert_sync_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> !sync);

   if (CE_DIV > 1) begin : g_ce_chk
      assert_ce_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
         ce |=> !ce);
   end

   assert_no_accept_in_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fe_reset) |-> !l1);

   assert_pattern_moves_with_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_pattern) |-> rd_req);

   assert_req_not_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !in_dead);

   assert_no_accept_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_dead && $past(in_dead)) |-> !l1);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= QCW'(Q_DEPTH));

   assert_ovf_steps_by_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf == $past(ovf)) || (ovf == $past(ovf) + OVF_W'(1)));

endmodule

bind coinc_trig_ctrl coinc_trig_ctrl_chk #(
   .PAT_W   (PAT_W),
   .OVF_W   (OVF_W),
   .Q_DEPTH (Q_DEPTH),
   .CE_DIV  (CE_DIV),
   .QCW     (QCW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fe_reset   (fe_reset_o),
   .sync       (fe_sync_o),
   .ce         (clk_en_o),
   .l1         (l1_accept_o),
   .rd_req     (rd_req_o),
   .rd_pattern (rd_pattern_o),
   .ovf        (ovf_count_o),
   .q_count    (q_count),
   .in_dead    (dead_phase)
);

// File: tb/sim_coinc_trig_ctrl.sv
`timescale 1ns/1ps
module sim_coinc_trig_ctrl;

   localparam int NS = 8;
   localparam int MM = 2;
   localparam int RL = 16;
   localparam int SP = 40;
   localparam int DL = 8;
   localparam int QD = 4;
   localparam int CD = 4;
   localparam int OW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] scint = '0;
   logic          done = 1'b0;
   logic          fe_reset, fe_sync, clk_en, l1, rd_req;
   logic [2*NS-1:0] rd_pattern;
   logic [OW-1:0] ovf;

   always #5 clk = ~clk;

   coinc_trig_ctrl #(
      .N_SCINT (NS), .MIN_MULT (MM), .RST_LEN (RL), .SYNC_PERIOD (SP),
      .DEAD_LEN (DL), .Q_DEPTH (QD), .CE_DIV (CD), .OVF_W (OW)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .scint_i (scint), .rd_done_i (done),
      .fe_reset_o (fe_reset), .fe_sync_o (fe_sync), .clk_en_o (clk_en),
      .l1_accept_o (l1), .rd_req_o (rd_req), .rd_pattern_o (rd_pattern),
      .ovf_count_o (ovf)
   );

   int cyc;
   int checks = 0, failures = 0;
   bit finished = 0;
   int l1_n = 0, l1_last = -1;
   int req_n = 0;
   int req_pat [64];
   int req_cyc [64];
   int sync_n = 0, sync_first = -1, sync_last = -1, sync_gap_bad = 0;
   int ce_n = 0, ce_bad = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // event recorder, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (l1) begin
            l1_n++;
            l1_last = cyc;
         end
         if (rd_req) begin
            req_pat[req_n & 63] = int'(rd_pattern);
            req_cyc[req_n & 63] = cyc;
            req_n++;
         end
         if (fe_sync) begin
            if (sync_n == 0) sync_first = cyc;
            else if (cyc - sync_last != SP) sync_gap_bad++;
            sync_last = cyc;
            sync_n++;
         end
         if (clk_en) begin
            if (cyc % CD != 0) ce_bad++;
            ce_n++;
         end
      end
   end

   task automatic check_eq(string rq, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic wait_until(int c);
      while (cyc < c) tick();
   endtask

   task automatic coin(input logic [NS-1:0] m, output int e);
      tick();
      scint = m;
      e = cyc + 1;
      tick();
      scint = '0;
   endtask

   task automatic give_done(output int d);
      tick();
      done = 1'b1;
      d = cyc + 1;
      tick();
      done = 1'b0;
   endtask

   task automatic done_coin(input logic [NS-1:0] m, output int d);
      tick();
      scint = m;
      done = 1'b1;
      d = cyc + 1;
      tick();
      scint = '0;
      done = 1'b0;
   endtask

   task automatic expect_req(string rq, int idx, int pat, int c);
      check_eq(rq, "request count", req_n, idx + 1);
      check_eq(rq, "trigger word", req_pat[idx & 63], pat);
      check_eq(rq, "request cycle", req_cyc[idx & 63], c);
   endtask

   task automatic t_reset();
      int e;
      check_eq("R1", "fe_reset at release", int'(fe_reset), 1);
      check_eq("R1", "l1 at reset", int'(l1), 0);
      check_eq("R1", "rd_req at reset", int'(rd_req), 0);
      check_eq("R1", "ovf at reset", int'(ovf), 0);
      coin(8'h03, e);
      tick();
      check_eq("R5", "accepts during init", l1_n, 0);
      wait_until(RL - 1);
      check_eq("R1", "fe_reset one cycle before end", int'(fe_reset), 1);
      tick();
      check_eq("R1", "fe_reset after RST_LEN edges", int'(fe_reset), 0);
   endtask

   task automatic t_sync_ce();
      wait_until(RL + 3 * SP + 1);
      check_eq("R2", "first sync cycle", sync_first, RL + SP);
      check_eq("R2", "sync count", sync_n, 3);
      check_eq("R2", "sync spacing errors", sync_gap_bad, 0);
      check_eq("R3", "enable phase errors", ce_bad, 0);
      check_eq("R3", "enable count", ce_n, cyc / CD);
   endtask

   task automatic t_single();
      int e, d, l0, r0;
      l0 = l1_n;
      coin(8'h10, e);
      repeat (3) tick();
      check_eq("R4", "single line accepts", l1_n, l0);
      r0 = req_n;
      coin(8'h03, e);
      wait_until(e + DL + 1);
      check_eq("R5", "accept cycle", l1_last, e);
      check_eq("R5", "accept count", l1_n, l0 + 1);
      expect_req("R6", r0, 16'h0303, e + DL);
      give_done(d);
      // one line held, then two more rise: edges 06, levels 07
      tick(); scint = 8'h01;
      repeat (3) tick();
      check_eq("R4", "held level accepts", l1_n, l0 + 1);
      scint = 8'h07;
      e = cyc + 1;
      repeat (4) tick();
      scint = '0;
      wait_until(e + DL + 1);
      check_eq("R4", "one accept for held rise", l1_n, l0 + 2);
      expect_req("R6", r0 + 1, 16'h0607, e + DL);
      give_done(d);
   endtask

   task automatic t_dead();
      int e, e2, d, l0, r0, o0;
      l0 = l1_n; r0 = req_n; o0 = int'(ovf);
      coin(8'h03, e);
      tick();
      coin(8'h0C, e2);
      wait_until(e + DL + 1);
      check_eq("R7", "accepts with window hit", l1_n, l0 + 1);
      check_eq("R7", "ovf after window hit", int'(ovf), o0);
      expect_req("R7", r0, 16'h0303, e + DL);
      give_done(d);
      repeat (4) tick();
      check_eq("R7", "window hit not queued", req_n, r0 + 1);
   endtask

   task automatic t_queue();
      int e, e1, e2, e3, d, l0, r0;
      l0 = l1_n; r0 = req_n;
      coin(8'h03, e);
      wait_until(e + DL + 1);
      expect_req("R8", r0, 16'h0303, e + DL);
      coin(8'h0C, e1);
      coin(8'h30, e2);
      coin(8'hC0, e3);
      tick();
      check_eq("R8", "accepts during readout", l1_n, l0 + 4);
      check_eq("R8", "last accept cycle", l1_last, e3);
      give_done(d);
      expect_req("R8", r0 + 1, 16'h0C0C, d);
      give_done(d);
      expect_req("R8", r0 + 2, 16'h3030, d);
      give_done(d);
      expect_req("R8", r0 + 3, 16'hC0C0, d);
      give_done(d);
      repeat (3) tick();
      check_eq("R10", "empty done issues nothing", req_n, r0 + 4);
   endtask

   task automatic t_overflow();
      int e, d, l0, r0, o0;
      l0 = l1_n; r0 = req_n; o0 = int'(ovf);
      coin(8'h03, e);
      wait_until(e + DL + 1);
      coin(8'h03, e);
      coin(8'h06, e);
      coin(8'h0C, e);
      coin(8'h18, e);
      coin(8'h30, e);
      tick();
      check_eq("R9", "accepts with full queue", l1_n, l0 + 5);
      check_eq("R9", "overflow count", int'(ovf), o0 + 1);
      // done and coincidence together while full
      done_coin(8'h60, d);
      expect_req("R10", r0 + 1, 16'h0303, d);
      check_eq("R10", "accept on full pop", l1_last, d);
      check_eq("R10", "no drop on full pop", int'(ovf), o0 + 1);
      give_done(d);
      expect_req("R9", r0 + 2, 16'h0606, d);
      give_done(d);
      expect_req("R9", r0 + 3, 16'h0C0C, d);
      give_done(d);
      expect_req("R9", r0 + 4, 16'h1818, d);
      give_done(d);
      expect_req("R10", r0 + 5, 16'h6060, d);
      // done and coincidence together with empty queue
      done_coin(8'h81, d);
      tick();
      check_eq("R10", "fresh accept on empty done", l1_last, d);
      wait_until(d + DL + 1);
      expect_req("R10", r0 + 6, 16'h8181, d + DL);
      give_done(d);
   endtask

   task automatic t_stray_done();
      int e, d, r0;
      r0 = req_n;
      give_done(d);
      repeat (3) tick();
      check_eq("R11", "idle done", req_n, r0);
      coin(8'h03, e);
      tick();
      give_done(d);
      wait_until(e + DL + 1);
      expect_req("R11", r0, 16'h0303, e + DL);
      repeat (3) tick();
      check_eq("R11", "window done", req_n, r0 + 1);
      give_done(d);
      repeat (2) tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_sync_ce();
      t_single();
      t_dead();
      t_queue();
      t_overflow();
      t_stray_done();
      check_eq("R2", "sync spacing at end", sync_gap_bad, 0);
      check_eq("R3", "enable phase at end", ce_bad, 0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule